// File: doc/BRIEF.md
# PWM Channel with Fractional Clock Divider

This block is a single pulse-width-modulation channel. A 16-bit counter moves forward on a clock enable. That enable comes from a divider whose ratio is an 8-bit integer plus a 4-bit fraction in sixteenths. The counter runs in one of two styles. In trailing-edge style it counts up and wraps after a programmable ceiling. In phase-correct style it climbs to the ceiling and then descends. Two outputs compare the counter against their own thresholds, and each output can be inverted.

The second pin can also work as an input. It is synchronised through two flops. Depending on the divider mode, it then either gates the divider or supplies the count steps itself, one step per rising edge or one per falling edge. Software can nudge a running counter by one count: a delay request swallows the next step, and a hurry request inserts an extra step in an idle divider cycle. Both request bits clear themselves when their adjustment has been applied.

The counter sequencing is a three-state machine. **CNT_OFF** (the reset state) moves to **CNT_UP** when the channel is enabled. **CNT_UP** moves to **CNT_DOWN** on a step at the ceiling in phase-correct style. **CNT_DOWN** moves back to **CNT_UP** on a step at zero, or on any step once trailing-edge style is selected. Both **CNT_UP** and **CNT_DOWN** return to **CNT_OFF** when the channel is disabled.

Top module: `pwm_slice_top`

## Requirements
- R1: After reset, the control word reads 0, the counter reads 0, the divider word reads 0x10, the ceiling reads 0xFFFF, both PWM outputs are low and `pwm_b_oe` is high.
- R2: The counter holds its value while the enable bit is 0. With enable set and a divider word of 0x10, the counter advances once per clock.
- R3: The divider produces one step every (integer + fraction/16) clocks on average. The extra clock is added each time a 4-bit fraction accumulator carries. An integer field of 0 means 256.
- R4: In trailing-edge style (control bit 1 = 0), the counter goes from the ceiling to 0. Output A is high while the counter is below threshold A, and output B is high while the counter is below threshold B.
- R5: In phase-correct style (control bit 1 = 1), the counter runs 0 up to the ceiling, repeats the ceiling, runs back down to 0 and repeats 0. One period is 2×(ceiling+1) steps.
- R6: Control bit 2 inverts output A and control bit 3 inverts output B, after the comparison.
- R7: Divider mode 1 (control bits 5:4) lets the divider run only while the synchronised pin B input is high.
- R8: Divider mode 2 steps the counter once per rising edge of pin B, and mode 3 steps it once per falling edge. In both modes the edges are seen after a two-flop synchroniser.
- R9: In divider modes 1, 2 and 3, `pwm_b` is held low and `pwm_b_oe` is low. In mode 0, `pwm_b_oe` is high.
- R10: Writing control bit 6 while enabling suppresses the next counter step, and the bit then reads back 0. A write with enable 0 leaves it unset.
- R11: Control bit 7 inserts one extra step in a divider idle cycle, but only when the ratio is above 1. With the ratio at exactly 1, the bit stays pending and the count rate is unchanged until a write with enable 0 clears it.
- R12: Register map (`reg_addr`): 0 is the control word (bit 0 enable, bit 1 style, bit 2 invert A, bit 3 invert B, bits 5:4 mode, bit 6 delay, bit 7 hurry). 1 is the divider word (bits 11:4 integer, bits 3:0 fraction). 2 is the counter, which is read-only, so writes are ignored. 3 holds threshold A in bits 15:0 and threshold B in bits 31:16. 4 holds the ceiling in bits 15:0. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_b_i | input | 1 | Pin B input level (gate or edge source) |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| pwm_b_oe | output | 1 | Drive enable for pin B (high only in mode 0) |

## Verification
Most corruption inside the block shows up in the counter rate, because the counter can be read at any time. A stuck fraction accumulator, or a wrong period reload, changes the number of steps counted over a fixed window within one divider period. A direction state stuck in CNT_UP or CNT_DOWN shows up within one PWM period, as missing repeated end values or missing descending steps in consecutive counter reads. A request bit that never clears, or that clears without acting, is caught within one divider period. It shows as a control word that still has the bit set, or as a step count that is off by exactly one.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    typedef enum logic [1:0] {
        DM_FREE = 2'd0,
        DM_GATE = 2'd1,
        DM_RISE = 2'd2,
        DM_FALL = 2'd3
    } div_mode_e;

    typedef enum logic [1:0] {
        CNT_OFF  = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_state_e;

    typedef struct packed {
        logic      hurry;
        logic      delay;
        div_mode_e mode;
        logic      inv_b;
        logic      inv_a;
        logic      phase_corr;
        logic      en;
    } ctrl_t;

endpackage

// File: rtl/pwm_pin_sync.sv
module pwm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level = sh_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
    parameter int IW = 8,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          gate,
    input  logic          edge_mode,
    input  logic          edge_pulse,
    input  logic [IW-1:0] div_int,
    input  logic [FW-1:0] div_frac,
    output logic          tick,
    output logic          ratio_gt1
);
    localparam int PW = IW + 1;

    logic [PW-1:0] cyc_q, cyc_next, int_eff, period;
    logic [FW-1:0] acc_q;
    logic          extra_q;
    logic [FW:0]   acc_sum;
    logic          div_tick;

    assign int_eff  = (div_int == '0) ? PW'(1 << IW) : PW'(div_int);
    assign period   = int_eff + PW'(extra_q);
    assign cyc_next = cyc_q + 1'b1;
    assign acc_sum  = {1'b0, acc_q} + {1'b0, div_frac};
    assign div_tick = run && gate && (cyc_next >= period);
    assign tick     = edge_mode ? (run && edge_pulse) : div_tick;
    assign ratio_gt1 = (div_int != IW'(1)) || (div_frac != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (!run) begin
            cyc_q   <= '0;
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (!edge_mode && gate) begin
            if (div_tick) begin
                cyc_q            <= '0;
                {extra_q, acc_q} <= acc_sum;
            end else begin
                cyc_q <= cyc_next;
            end
        end
    end

    p_gate_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && !gate) |-> !tick);

    p_gate_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && !gate) |=> $stable(cyc_q));
endmodule

// File: rtl/pwm_counter_fsm.sv
module pwm_counter_fsm
    import pwm_slice_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          phase_corr,
    input  logic [CW-1:0] top,
    input  logic          tick,
    input  logic          delay_req,
    input  logic          hurry_req,
    input  logic          hurry_ok,
    output logic [CW-1:0] ctr,
    output logic          delay_done,
    output logic          hurry_done
);
    cnt_state_e    state_q, state_d;
    logic [CW-1:0] ctr_q, ctr_d;
    logic          do_step, at_top;
    cnt_state_e    up_state;
    logic [CW-1:0] up_ctr;

    assign delay_done = en && tick && delay_req;
    assign hurry_done = en && !tick && hurry_req && hurry_ok;
    assign do_step    = (tick && !delay_req) || hurry_done;
    assign at_top     = (ctr_q >= top);

    always_comb begin
        if (at_top && phase_corr) begin
            up_state = CNT_DOWN;
            up_ctr   = ctr_q;
        end else if (at_top) begin
            up_state = CNT_UP;
            up_ctr   = '0;
        end else begin
            up_state = CNT_UP;
            up_ctr   = ctr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        ctr_d   = ctr_q;
        unique case (state_q)
            CNT_OFF: begin
                if (en) begin
                    state_d = CNT_UP;
                    if (do_step) begin
                        state_d = up_state;
                        ctr_d   = up_ctr;
                    end
                end
            end
            CNT_UP: begin
                if (!en) begin
                    state_d = CNT_OFF;
                end else if (do_step) begin
                    state_d = up_state;
                    ctr_d   = up_ctr;
                end
            end
            CNT_DOWN: begin
                if (!en) begin
                    state_d = CNT_OFF;
                end else if (do_step) begin
                    if (!phase_corr) begin
                        state_d = up_state;
                        ctr_d   = up_ctr;
                    end else if (ctr_q == '0) begin
                        state_d = CNT_UP;
                    end else begin
                        ctr_d = ctr_q - 1'b1;
                    end
                end
            end
            default: state_d = CNT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_OFF;
            ctr_q   <= '0;
        end else begin
            state_q <= state_d;
            ctr_q   <= ctr_d;
        end
    end

    assign ctr = ctr_q;

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ctr_q));

    p_trail_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && do_step && !phase_corr && at_top) |=> (ctr_q == '0));

    p_pc_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && do_step && phase_corr && state_q == CNT_UP && at_top)
        |=> (state_q == CNT_DOWN && $stable(ctr_q)));
endmodule

// File: rtl/pwm_slice_top.sv
module pwm_slice_top
    import pwm_slice_pkg::*;
#(
    parameter int CW = 16,
    parameter int IW = 8,
    parameter int FW = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        pin_b_i,
    output logic        pwm_a,
    output logic        pwm_b,
    output logic        pwm_b_oe
);
    localparam int DW = IW + FW;

    ctrl_t         ctrl_q;
    logic [IW-1:0] div_int_q;
    logic [FW-1:0] div_frac_q;
    logic [CW-1:0] cmp_a_q, cmp_b_q, top_q, ctr;
    logic          ctrl_we, en_next, delay_next, hurry_next;
    logic          b_level, b_rise, b_fall;
    logic          gate, edge_mode, edge_pulse, tick, ratio_gt1;
    logic          delay_done, hurry_done;

    assign ctrl_we    = reg_we && (reg_addr == 3'd0);
    assign en_next    = ctrl_we ? reg_wdata[0] : ctrl_q.en;
    assign delay_next = en_next && ((ctrl_q.delay && !delay_done) || (ctrl_we && reg_wdata[6]));
    assign hurry_next = en_next && ((ctrl_q.hurry && !hurry_done) || (ctrl_we && reg_wdata[7]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            div_int_q  <= IW'(1);
            div_frac_q <= '0;
            cmp_a_q    <= '0;
            cmp_b_q    <= '0;
            top_q      <= '1;
        end else begin
            ctrl_q.delay <= delay_next;
            ctrl_q.hurry <= hurry_next;
            if (ctrl_we) begin
                ctrl_q.en         <= reg_wdata[0];
                ctrl_q.phase_corr <= reg_wdata[1];
                ctrl_q.inv_a      <= reg_wdata[2];
                ctrl_q.inv_b      <= reg_wdata[3];
                ctrl_q.mode       <= div_mode_e'(reg_wdata[5:4]);
            end
            if (reg_we && reg_addr == 3'd1) {div_int_q, div_frac_q} <= reg_wdata[DW-1:0];
            if (reg_we && reg_addr == 3'd3) begin
                cmp_a_q <= reg_wdata[CW-1:0];
                cmp_b_q <= reg_wdata[16+CW-1:16];
            end
            if (reg_we && reg_addr == 3'd4) top_q <= reg_wdata[CW-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            3'd0:    reg_rdata[7:0]     = ctrl_q;
            3'd1:    reg_rdata[DW-1:0]  = {div_int_q, div_frac_q};
            3'd2:    reg_rdata[CW-1:0]  = ctr;
            3'd3:    reg_rdata = {cmp_b_q, cmp_a_q};
            3'd4:    reg_rdata[CW-1:0]  = top_q;
            default: reg_rdata = '0;
        endcase
    end

    pwm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_b_i),
        .level(b_level), .rise(b_rise), .fall(b_fall)
    );

    assign gate       = (ctrl_q.mode == DM_GATE) ? b_level : 1'b1;
    assign edge_mode  = ctrl_q.mode[1];
    assign edge_pulse = (ctrl_q.mode == DM_RISE) ? b_rise : b_fall;

    pwm_frac_div #(.IW(IW), .FW(FW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .gate(gate),
        .edge_mode(edge_mode), .edge_pulse(edge_pulse),
        .div_int(div_int_q), .div_frac(div_frac_q),
        .tick(tick), .ratio_gt1(ratio_gt1)
    );

    pwm_counter_fsm #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .phase_corr(ctrl_q.phase_corr),
        .top(top_q), .tick(tick), .delay_req(ctrl_q.delay),
        .hurry_req(ctrl_q.hurry), .hurry_ok(ratio_gt1), .ctr(ctr),
        .delay_done(delay_done), .hurry_done(hurry_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_a <= 1'b0;
            pwm_b <= 1'b0;
        end else begin
            pwm_a <= (ctr < cmp_a_q) ^ ctrl_q.inv_a;
            pwm_b <= (ctrl_q.mode == DM_FREE) ? ((ctr < cmp_b_q) ^ ctrl_q.inv_b) : 1'b0;
        end
    end

    assign pwm_b_oe = (ctrl_q.mode == DM_FREE);

    p_b_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode != DM_FREE) |=> !pwm_b);

    p_delay_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_done && !ctrl_we) |=> !ctrl_q.delay);

    p_hurry_gt1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.hurry && !ratio_gt1 && !ctrl_we && ctrl_q.en) |=> ctrl_q.hurry);
endmodule

// File: tb/sim_pwm_slice_top.sv
`timescale 1ns/100ps
module sim_pwm_slice_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pin_b_i = 1'b0;
    logic        pwm_a, pwm_b, pwm_b_oe;

    int checks = 0;
    int failures = 0;
    logic [15:0] s0, s1;

    always #2.5 clk = ~clk;

    pwm_slice_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_b_i(pin_b_i),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd2;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_addr = 3'd2;
    endtask

    task automatic snap(output logic [15:0] v);
        logic [31:0] d;
        rd(3'd2, d);
        v = d[15:0];
    endtask

    task automatic count_hi(input bit sel_b, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            hi += sel_b ? int'(pwm_b) : int'(pwm_a);
        end
    endtask

    task automatic rate(input int n, input int exp, input string req);
        snap(s0); wcyc(n); snap(s1);
        chk(req, 32'(s1 - s0), 32'(exp));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, d); chk("R1 ctrl", d, 0);
        rd(3'd2, d); chk("R1 counter", d, 0);
        rd(3'd1, d); chk("R1 divider", d, 32'h10);
        rd(3'd4, d); chk("R1 ceiling", d, 32'hFFFF);
        chk("R1 pwm_a", 32'(pwm_a), 0);
        chk("R1 pwm_b", 32'(pwm_b), 0);
        chk("R1 oe", 32'(pwm_b_oe), 1);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(3'd3, 32'h0007_0003);
        rd(3'd3, d); chk("R12 thresholds", d, 32'h0007_0003);
        wr(3'd2, 32'h1234);
        rd(3'd2, d); chk("R12 counter write ignored", d, 0);
        rd(3'd7, d); chk("R12 unmapped", d, 0);
    endtask

    task automatic t_enable;
        rate(20, 0, "R2 hold while disabled");
        wr(3'd0, 32'h01);
        rate(10, 10, "R2 full rate");
    endtask

    task automatic t_divider;
        wr(3'd1, 32'h40); wcyc(10);
        rate(40, 10, "R3 integer 4");
        wr(3'd1, 32'h28); wcyc(20);
        rate(80, 32, "R3 ratio 2.5");
        wr(3'd1, 32'h00); wcyc(300);
        rate(512, 2, "R3 integer 0 as 256");
        wr(3'd1, 32'h10); wcyc(5);
    endtask

    task automatic t_delay;
        logic [31:0] d;
        snap(s0); wr(3'd0, 32'h41); wcyc(9); snap(s1);
        chk("R10 one step swallowed", 32'(s1 - s0), 9);
        rd(3'd0, d); chk("R10 self clear", d, 32'h01);
        wr(3'd0, 32'h40);
        rd(3'd0, d); chk("R10 ignored when disabled", d, 32'h00);
        wr(3'd0, 32'h01);
        rate(10, 10, "R10 no later effect");
    endtask

    task automatic t_hurry;
        logic [31:0] d;
        wr(3'd1, 32'h40); wcyc(10);
        snap(s0); wr(3'd0, 32'h81); wcyc(39); snap(s1);
        chk("R11 one step inserted", 32'(s1 - s0), 11);
        rd(3'd0, d); chk("R11 self clear", d, 32'h01);
        wr(3'd1, 32'h10); wcyc(5);
        snap(s0); wr(3'd0, 32'h81); wcyc(9); snap(s1);
        chk("R11 blocked at ratio 1", 32'(s1 - s0), 10);
        rd(3'd0, d); chk("R11 stays pending", d, 32'h81);
        wr(3'd0, 32'h00);
        rd(3'd0, d); chk("R11 cleared by disable", d, 32'h00);
        wr(3'd0, 32'h01);
    endtask

    task automatic t_trailing;
        int hi;
        wr(3'd4, 32'd9); wr(3'd3, 32'h0007_0003); wcyc(20);
        count_hi(1'b0, 100, hi); chk("R4 A duty", 32'(hi), 30);
        count_hi(1'b1, 100, hi); chk("R4 B duty", 32'(hi), 70);
        wr(3'd0, 32'h09); wcyc(3);
        count_hi(1'b1, 100, hi); chk("R6 B inverted", 32'(hi), 30);
        wr(3'd0, 32'h05); wcyc(3);
        count_hi(1'b0, 100, hi); chk("R6 A inverted", 32'(hi), 70);
        wr(3'd0, 32'h01); wr(3'd3, 32'h0007_0000); wcyc(3);
        count_hi(1'b0, 100, hi); chk("R4 threshold 0", 32'(hi), 0);
        wr(3'd3, 32'h0007_000A); wcyc(3);
        count_hi(1'b0, 100, hi); chk("R4 threshold above ceiling", 32'(hi), 100);
    endtask

    task automatic t_wrap;
        logic [15:0] prev, cur;
        int bad = 0;
        wr(3'd4, 32'd4); wcyc(10);
        snap(prev);
        for (int i = 0; i < 12; i++) begin
            wcyc(1); snap(cur);
            if (cur != ((prev >= 16'd4) ? 16'd0 : prev + 16'd1)) bad++;
            prev = cur;
        end
        chk("R4 wrap sequence errors", 32'(bad), 0);
    endtask

    task automatic t_phase;
        logic [15:0] prev, cur;
        int rep = 0, dec = 0, hi;
        wr(3'd4, 32'd9); wr(3'd3, 32'h0007_0003); wr(3'd0, 32'h03); wcyc(40);
        snap(prev);
        for (int i = 0; i < 200; i++) begin
            wcyc(1); snap(cur);
            if (cur == prev) rep++;
            if (cur == prev - 16'd1) dec++;
            prev = cur;
        end
        chk("R5 repeated ends", 32'(rep), 20);
        chk("R5 descending steps", 32'(dec), 90);
        count_hi(1'b0, 200, hi); chk("R5 A duty", 32'(hi), 60);
    endtask

    task automatic t_modes;
        wr(3'd4, 32'hFFFF);
        pin_b_i = 1'b0;
        wr(3'd0, 32'h19); wcyc(5);
        rate(20, 0, "R7 gate low");
        pin_b_i = 1'b1; wcyc(5);
        rate(20, 20, "R7 gate high");
        chk("R9 pwm_b low", 32'(pwm_b), 0);
        chk("R9 oe low", 32'(pwm_b_oe), 0);
        pin_b_i = 1'b0;
        wr(3'd0, 32'h21); wcyc(5);
        snap(s0);
        for (int i = 0; i < 5; i++) begin
            pin_b_i = 1'b1; wcyc(4); pin_b_i = 1'b0; wcyc(4);
        end
        wcyc(5); snap(s1);
        chk("R8 rising edges", 32'(s1 - s0), 5);
        wr(3'd0, 32'h31); wcyc(5);
        snap(s0); pin_b_i = 1'b1; wcyc(6); snap(s1);
        chk("R8 falling mode ignores rise", 32'(s1 - s0), 0);
        pin_b_i = 1'b0; wcyc(6); snap(s1);
        chk("R8 falling edge", 32'(s1 - s0), 1);
        chk("R9 pwm_b low edge mode", 32'(pwm_b), 0);
        wr(3'd0, 32'h01);
        chk("R9 oe high in mode 0", 32'(pwm_b_oe), 1);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5.0);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        reg_addr = 3'd2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wcyc(1);
        t_reset();
        t_regmap();
        t_enable();
        t_divider();
        t_delay();
        t_hurry();
        t_trailing();
        t_wrap();
        t_phase();
        t_modes();
        report();
    end
endmodule